// File: doc/BRIEF.md
# Paged Register Access Sequencer

This block sits between a control engine that thinks in 16-bit logical register numbers and a byte-wide port to a device whose registers are banked into pages. Each logical number holds a page and an address within that page. The block turns one command into the short run of byte transactions the device needs. It selects the page only when the page has changed. It performs bit-set and bit-clear as a read followed by a write-back, with no other command able to interleave. It also issues a two-byte burst for 16-bit values.

The command side accepts one command at a time: `cmd_ready` is high only while the block is idle. Read data comes back on a result port with a one-cycle valid pulse. The byte side is a level request held until the responder returns an acknowledge or an error pulse. An error ends the command at once and leaves a sticky flag, which is cleared when the next command is accepted.

Top module: `pgreg_seq`

## Requirements
- R1: Bits [15:8] of `cmd_reg` are the page and bits [7:0] are the in-page address. Every data transaction of a command uses that in-page address, and a read returns the byte stored there in the addressed page.
- R2: A page change is made with a single-byte write (`bus_kind` 0) of the page number to in-page address 0xFF. It is issued before any data transaction of the command.
- R3: A page-select write is issued only when the command's page differs from the cached page. The cache takes the new page only after that write is acknowledged without error.
- R4: After reset the cached page is 0xFF. A first command to page 0xFF therefore issues no select, and a first command to any other page issues one.
- R5: Set-bits (`cmd_op` 2) reads the byte (`bus_kind` 1), ORs in the mask `cmd_data[7:0]`, and writes the result back to the same address.
- R6: Clear-bits (`cmd_op` 3) reads the byte, ANDs it with the inverted mask `cmd_data[7:0]`, and writes the result back.
- R7: A 16-bit write (`cmd_op` 4) is one burst (`bus_kind` 2) at the given address. `bus_wdata[15:8]` (taken from `cmd_data[15:8]`) lands at that address and `bus_wdata[7:0]` at the next one.
- R8: A byte write (`cmd_op` 0) stores `cmd_data[7:0]`; a read (`cmd_op` 1) stores nothing.
- R9: `busy` rises on the edge that accepts a command and falls with the last transaction's response. A `cmd_valid` seen while busy is ignored.
- R10: A read returns its byte on `rd_data` with `rd_valid` high for exactly one cycle, in the cycle `busy` falls. Other commands give no pulse.
- R11: An error response (`bus_err`) ends the command with no further transactions. It sets `err_flag` in the cycle `busy` falls, and the flag holds until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_op | input | 3 | 0 write, 1 read, 2 set bits, 3 clear bits, 4 16-bit write |
| cmd_reg | input | 16 | Page in [15:8], in-page address in [7:0] |
| cmd_data | input | 16 | Byte or mask in [7:0]; high byte for 16-bit write in [15:8] |
| busy | output | 1 | Command in progress |
| rd_valid | output | 1 | One-cycle pulse, read byte valid |
| rd_data | output | 8 | Read byte |
| err_flag | output | 1 | Last command ended on an error response |
| bus_req | output | 1 | Byte transaction requested, held until response |
| bus_kind | output | 2 | 0 byte write, 1 byte read, 2 two-byte burst write |
| bus_addr | output | 8 | In-page address of the transaction |
| bus_wdata | output | 16 | Write data; single byte in [7:0] |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |
| bus_ack | input | 1 | Transaction completed |
| bus_err | input | 1 | Transaction failed |

## Verification
Directed commands come first. A command to page 0xFF straight after reset separates a cache that resets to 0xFF from one that resets elsewhere. Repeated same-page commands show whether the select is skipped. Set and clear masks with mixed bit values expose swapped or missing mask logic, and a 16-bit value with distinct halves exposes byte-order errors. Error responses injected on the page select and on the read phase of a set show that the cache is left alone and that the write-back is dropped. A command offered while busy shows that it is ignored. Several hundred random commands over seven pages, with random response latency and occasional errors, are then checked against a bench model of the device's memory and the expected page-select and transaction counts.

// File: rtl/pgreg_pkg.sv
// Shared types for the paged register sequencer.
// Assumes the opcode and bus-kind encodings listed in the brief.
package pgreg_pkg;
    typedef enum logic [2:0] {
        OP_WR   = 3'd0,
        OP_RD   = 3'd1,
        OP_SET  = 3'd2,
        OP_CLR  = 3'd3,
        OP_WR16 = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        BK_WR    = 2'd0,
        BK_RD    = 2'd1,
        BK_BURST = 2'd2
    } bkind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEL,
        ST_ACC,
        ST_WB
    } st_e;
endpackage

// File: rtl/pgreg_page_cache.sv
// Holds the page currently selected in the device and compares it with a
// probe page. Assumes that upd is raised only for an acknowledged select.
module pgreg_page_cache #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] probe_page,
    input  logic              upd,
    input  logic [PAGE_W-1:0] new_page,
    output logic              hit,
    output logic [PAGE_W-1:0] cur_page
);
    localparam logic [PAGE_W-1:0] RESET_PAGE = {PAGE_W{1'b1}};

    // Cached page register: all ones after reset, loaded on a confirmed select.
    always_ff @(posedge clk) begin
        if (!rst_n)   cur_page <= RESET_PAGE;
        else if (upd) cur_page <= new_page;
    end

    // Hit when the probe page is already selected.
    always_comb hit = (probe_page == cur_page);

    // R3
    cache_only_on_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_page) |-> $past(upd))
        else $error("cached page changed without a confirmed select");
endmodule

// File: rtl/pgreg_modify.sv
// Computes the write-back byte of a read-modify-write: OR for set, AND-NOT
// for clear. Purely combinational; other opcodes give the clear result.
module pgreg_modify
    import pgreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] rd_byte,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] wb_byte
);
    // Merge the mask into the byte read back.
    always_comb wb_byte = (op == OP_SET) ? (rd_byte | mask) : (rd_byte & ~mask);
endmodule

// File: rtl/pgreg_ctrl.sv
// Command sequencer: accepts one command when idle, then issues an optional
// page select, the data access and an optional write-back. Assumes bus_ack
// and bus_err are single-cycle pulses answering the request held high.
module pgreg_ctrl
    import pgreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  op_e                 cmd_op,
    input  logic [DATA_W-1:0]   cmd_page,
    input  logic [ADDR_W-1:0]   cmd_offs,
    input  logic [2*DATA_W-1:0] cmd_data,
    input  logic                hit,
    input  logic [DATA_W-1:0]   cache_page,
    input  logic [DATA_W-1:0]   wb_byte,
    output logic                cmd_ready,
    output logic                busy,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                err_flag,
    output logic                cache_upd,
    output logic [DATA_W-1:0]   page_q,
    output op_e                 op_q,
    output logic [DATA_W-1:0]   mask_q,
    output logic                bus_req,
    output bkind_e              bus_kind,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [2*DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_ack,
    input  logic                bus_err
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = {ADDR_W{1'b1}};
    localparam logic [DATA_W-1:0] ZB       = '0;

    st_e                 state;
    logic [ADDR_W-1:0]   offs_q;
    logic [2*DATA_W-1:0] data_q;
    logic [DATA_W-1:0]   rmw_q;
    logic                accept;

    assign accept    = cmd_valid && (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign cmd_ready = !busy;
    assign mask_q    = data_q[DATA_W-1:0];
    assign cache_upd = (state == ST_SEL) && bus_ack && !bus_err;

    // Sequencer state, command latch and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            offs_q   <= '0;
            page_q   <= '0;
            data_q   <= '0;
            op_q     <= OP_WR;
            rmw_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            err_flag <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    op_q     <= cmd_op;
                    page_q   <= cmd_page;
                    offs_q   <= cmd_offs;
                    data_q   <= cmd_data;
                    err_flag <= 1'b0;
                    state    <= hit ? ST_ACC : ST_SEL;
                end
                ST_SEL: begin
                    if (bus_err) begin
                        err_flag <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (bus_ack) begin
                        state <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (bus_err) begin
                        err_flag <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (bus_ack) begin
                        case (op_q)
                            OP_RD: begin
                                rd_data  <= bus_rdata;
                                rd_valid <= 1'b1;
                                state    <= ST_IDLE;
                            end
                            OP_SET, OP_CLR: begin
                                rmw_q <= wb_byte;
                                state <= ST_WB;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_WB: begin
                    if (bus_err) begin
                        err_flag <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (bus_ack) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Byte-port request decoded from the current step.
    always_comb begin
        bus_req   = busy;
        bus_kind  = BK_WR;
        bus_addr  = offs_q;
        bus_wdata = {ZB, data_q[DATA_W-1:0]};
        case (state)
            ST_SEL: begin
                bus_addr  = SEL_ADDR;
                bus_wdata = {ZB, page_q};
            end
            ST_ACC: begin
                case (op_q)
                    OP_RD, OP_SET, OP_CLR: bus_kind = BK_RD;
                    OP_WR16: begin
                        bus_kind  = BK_BURST;
                        bus_wdata = data_q;
                    end
                    default: bus_kind = BK_WR;
                endcase
            end
            ST_WB: bus_wdata = {ZB, rmw_q};
            default: ;
        endcase
    end

    // R3
    cache_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEL && bus_ack && !bus_err) |=> (cache_page == $past(page_q)))
        else $error("cache not loaded after select");

    // R3
    cache_keep_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEL && bus_err) |=> $stable(cache_page))
        else $error("cache changed on failed select");

    // R5
    set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB && bus_req && op_q == OP_SET) |->
            ((bus_wdata[DATA_W-1:0] & mask_q) == mask_q))
        else $error("set write-back lacks mask bits");

    // R6
    clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB && bus_req && op_q == OP_CLR) |->
            ((bus_wdata[DATA_W-1:0] & mask_q) == '0))
        else $error("clear write-back keeps mask bits");

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(page_q) && $stable(offs_q) && $stable(data_q)))
        else $error("command latch changed while busy");

    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid)
        else $error("read valid longer than one cycle");

    // R10
    rd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_ack && !bus_err && op_q == OP_RD))
        else $error("read valid without read response");
endmodule

// File: rtl/pgreg_seq.sv
// Top of the paged register sequencer: splits the logical register number,
// ties the page cache, the modify unit and the sequencer together.
// Assumes the device selects its page through in-page address all-ones.
module pgreg_seq
    import pgreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int REG_W = ADDR_W + DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [2:0]          cmd_op,
    input  logic [REG_W-1:0]    cmd_reg,
    input  logic [2*DATA_W-1:0] cmd_data,
    output logic                busy,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                err_flag,
    output logic                bus_req,
    output logic [1:0]          bus_kind,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [2*DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_ack,
    input  logic                bus_err
);
    logic [DATA_W-1:0] cmd_page;
    logic [ADDR_W-1:0] cmd_offs;
    logic              hit, cache_upd;
    logic [DATA_W-1:0] cache_page, page_q, mask_q, wb_byte;
    op_e               op_q;
    bkind_e            kind;

    assign cmd_page = cmd_reg[REG_W-1:ADDR_W];
    assign cmd_offs = cmd_reg[ADDR_W-1:0];
    assign bus_kind = kind;

    pgreg_page_cache #(.PAGE_W(DATA_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .probe_page(cmd_page), .upd(cache_upd),
        .new_page(page_q), .hit(hit), .cur_page(cache_page)
    );

    pgreg_modify #(.DATA_W(DATA_W)) u_mod (
        .op(op_q), .rd_byte(bus_rdata), .mask(mask_q), .wb_byte(wb_byte)
    );

    pgreg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_e'(cmd_op)),
        .cmd_page(cmd_page), .cmd_offs(cmd_offs), .cmd_data(cmd_data),
        .hit(hit), .cache_page(cache_page), .wb_byte(wb_byte),
        .cmd_ready(cmd_ready), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_flag(err_flag), .cache_upd(cache_upd), .page_q(page_q), .op_q(op_q),
        .mask_q(mask_q), .bus_req(bus_req), .bus_kind(kind), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
    );
endmodule

// File: tb/pgreg_seq_test.sv
module pgreg_seq_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cmd_valid, cmd_ready, busy, rd_valid, err_flag;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_reg, cmd_data, bus_wdata;
    logic [7:0]  rd_data, bus_addr, bus_rdata;
    logic [1:0]  bus_kind;
    logic        bus_req, bus_ack, bus_err;

    int vectors = 0, misses = 0;
    bit finished = 0;

    logic [7:0] dev_mem [0:7][0:255];
    logic [7:0] exp_mem [0:7][0:255];
    logic [7:0] dev_page, exp_cache;
    int txn_cnt = 0, sel_cnt = 0, burst_cnt = 0, fail_at = -1;

    pgreg_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_flag(err_flag),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
    );

    function automatic int pidx(input logic [7:0] p);
        return (p == 8'hFF) ? 7 : int'(p[2:0]);
    endfunction

    function automatic logic [7:0] rmw(input logic [2:0] op, input logic [7:0] old, input logic [7:0] m);
        return (op == 3'd2) ? (old | m) : (old & ~m);
    endfunction

    function automatic string tagof(input logic [2:0] op);
        case (op)
            3'd0: return "R8 byte write";
            3'd1: return "R1 read";
            3'd2: return "R5 set bits";
            3'd3: return "R6 clear bits";
            default: return "R7 16-bit write";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Device model on the byte port, with random latency and injected errors.
    initial begin
        int wait_cnt, lat;
        wait_cnt = 0; lat = 0;
        bus_ack = 0; bus_err = 0; bus_rdata = 0; dev_page = 8'hFF;
        forever begin
            @(negedge clk);
            if (bus_ack || bus_err) begin
                bus_ack = 0; bus_err = 0;
            end else if (bus_req && rst_n) begin
                if (wait_cnt < lat) wait_cnt++;
                else begin
                    wait_cnt = 0;
                    lat = int'($urandom % 3);
                    txn_cnt++;
                    if (bus_kind == 2'd0 && bus_addr == 8'hFF) sel_cnt++;
                    if (txn_cnt == fail_at) bus_err = 1;
                    else begin
                        bus_ack = 1;
                        case (bus_kind)
                            2'd0: if (bus_addr == 8'hFF) dev_page = bus_wdata[7:0];
                                  else dev_mem[pidx(dev_page)][bus_addr] = bus_wdata[7:0];
                            2'd1: bus_rdata = dev_mem[pidx(dev_page)][bus_addr];
                            default: begin
                                burst_cnt++;
                                dev_mem[pidx(dev_page)][bus_addr] = bus_wdata[15:8];
                                dev_mem[pidx(dev_page)][bus_addr + 8'd1] = bus_wdata[7:0];
                            end
                        endcase
                    end
                end
            end
        end
    end

    task automatic run(input logic [2:0] op, input logic [7:0] pg, input logic [7:0] off,
                       input logic [15:0] dat, input int fail_rel, input bit glitch);
        int s0, t0, b0, exp_sel, exp_txn, n, pi;
        logic [7:0] rd;
        bit rv, er;
        string tg;
        tg = tagof(op);
        while (!cmd_ready) @(negedge clk);
        s0 = sel_cnt; t0 = txn_cnt; b0 = burst_cnt;
        fail_at = (fail_rel > 0) ? txn_cnt + fail_rel : -1;
        cmd_valid = 1; cmd_op = op; cmd_reg = {pg, off}; cmd_data = dat;
        @(negedge clk);
        cmd_valid = 0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        if (glitch) begin
            cmd_valid = 1; cmd_op = 3'd0; cmd_reg = 16'h0180; cmd_data = 16'h00A5;
            @(negedge clk);
            cmd_valid = 0;
        end
        n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
        rd = rd_data; rv = rd_valid; er = err_flag;
        exp_sel = (pg != exp_cache) ? 1 : 0;
        exp_txn = (fail_rel > 0) ? fail_rel : exp_sel + ((op == 3'd2 || op == 3'd3) ? 2 : 1);
        chk(sel_cnt - s0 == exp_sel, "R3 page-select count", sel_cnt - s0, exp_sel);
        chk(txn_cnt - t0 == exp_txn, "R11 transaction count", txn_cnt - t0, exp_txn);
        chk(er == (fail_rel > 0), "R11 error flag", int'(er), int'(fail_rel > 0));
        if (exp_sel == 1 && fail_rel != 1) exp_cache = pg;
        pi = pidx(pg);
        if (fail_rel == 0) begin
            case (op)
                3'd0: exp_mem[pi][off] = dat[7:0];
                3'd1: begin
                    chk(rv, "R10 read valid pulse", int'(rv), 1);
                    chk(rd == exp_mem[pi][off], "R1 read data", rd, exp_mem[pi][off]);
                end
                3'd2, 3'd3: exp_mem[pi][off] = rmw(op, exp_mem[pi][off], dat[7:0]);
                default: begin
                    exp_mem[pi][off] = dat[15:8];
                    exp_mem[pi][off + 8'd1] = dat[7:0];
                    chk(burst_cnt - b0 == 1, "R7 one burst", burst_cnt - b0, 1);
                    chk(dev_mem[pi][off + 8'd1] == exp_mem[pi][off + 8'd1], "R7 low byte",
                        dev_mem[pi][off + 8'd1], exp_mem[pi][off + 8'd1]);
                end
            endcase
        end
        if (op != 3'd1 || fail_rel > 0) chk(!rv, "R10 no pulse", int'(rv), 0);
        chk(dev_mem[pi][off] == exp_mem[pi][off], tg, dev_mem[pi][off], exp_mem[pi][off]);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10 single-cycle pulse", int'(rd_valid), 0);
        if (glitch)
            chk(dev_mem[1][8'h80] == exp_mem[1][8'h80], "R9 command while busy ignored",
                dev_mem[1][8'h80], exp_mem[1][8'h80]);
        fail_at = -1;
    endtask

    initial begin
        for (int p = 0; p < 8; p++)
            for (int a = 0; a < 256; a++) begin
                dev_mem[p][a] = 8'((p * 37 + a * 11) & 255);
                exp_mem[p][a] = 8'((p * 37 + a * 11) & 255);
            end
        void'($urandom(32'h5EED));
        rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_reg = 0; cmd_data = 0;
        exp_cache = 8'hFF;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !rd_valid && !err_flag && cmd_ready, "R9 reset state",
            {busy, bus_req, rd_valid, err_flag, cmd_ready}, 1);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !bus_req, "R9 idle after reset", {busy, bus_req}, 0);

        run(3'd1, 8'hFF, 8'h10, 16'h0, 0, 0);          // R4: no select for page 0xFF
        run(3'd0, 8'h02, 8'h33, 16'h005C, 0, 0);       // R2: select then write
        chk(dev_page == 8'h02, "R2 select carries page", dev_page, 2);
        run(3'd1, 8'h02, 8'h33, 16'h0, 0, 0);          // R3: hit, no select
        run(3'd2, 8'h02, 8'h33, 16'h0081, 0, 0);       // R5
        chk(dev_mem[2][8'h33] == 8'hDD, "R5 set result", dev_mem[2][8'h33], 8'hDD);
        run(3'd3, 8'h02, 8'h33, 16'h000C, 0, 0);       // R6
        chk(dev_mem[2][8'h33] == 8'hD1, "R6 clear result", dev_mem[2][8'h33], 8'hD1);
        run(3'd4, 8'h03, 8'h40, 16'hBEEF, 0, 0);       // R7
        chk(dev_mem[3][8'h40] == 8'hBE, "R7 high byte first", dev_mem[3][8'h40], 8'hBE);
        run(3'd0, 8'h03, 8'h22, 16'h0011, 0, 1);       // R9 glitch while busy
        run(3'd0, 8'h05, 8'h07, 16'h0077, 1, 0);       // R11 error on select
        run(3'd1, 8'h05, 8'h07, 16'h0, 0, 0);          // R3 select retried, R11 flag cleared
        run(3'd2, 8'h05, 8'h09, 16'h00F0, 1, 0);       // R11 error on read phase
        run(3'd1, 8'h05, 8'h09, 16'h0, 0, 0);

        for (int i = 0; i < 300; i++) begin
            logic [2:0] op;
            logic [7:0] pg, off;
            op  = 3'($urandom % 5);
            pg  = 8'($urandom % 7);
            off = 8'($urandom % 254);
            run(op, pg, off, 16'($urandom), ($urandom % 10 == 0) ? 1 : 0, 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++; misses++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule